// File: doc/BRIEF.md
# Write-Through Snooping Line Controller

This block keeps a small direct-mapped, write-through data cache coherent with the other agents on a shared snooping bus. Each line holds one data word, one tag and a two-valued state: `LN_INV` (nothing usable held) or `LN_VAL` (a clean copy of memory). A processor port takes one read or write request at a time and answers with a done pulse, a hit flag and read data. A bus master port raises a request to an external arbiter, holds one transaction until it is granted, and issues three kinds of transaction: block read, read-for-ownership and word write. Every store reaches memory through a word write, so the cache never holds data that memory lacks.

A snoop port carries the transactions of other agents. It is compared against a second copy of the tag array, so a snoop never competes with the processor lookup for a read port. When another agent writes or reads-for-ownership a block that a line holds valid, the line drops to `LN_INV` in that cycle. The controller never answers on the bus. When a snoop kills a line in the same cycle as a processor lookup of that line, the snoop wins and the lookup sees a miss.

The control is one state machine with three states. `ST_IDLE` looks up the tags. It takes the transition *idle-to-resp* on a read hit and *idle-to-bus* on any other request. `ST_BUS` holds the bus request. It takes *bus-to-bus* after a granted read-for-ownership, which turns the pending command into a word write, and *bus-to-resp* after any other grant. `ST_RESP` drives the done pulse and takes *resp-to-idle*.

Top module: `wt_snoop_ctrl`

## Requirements
- R1: After reset every line is `LN_INV`, `bus_req` and `cpu_done` are 0, and the first read of any address reports a miss.
- R2: A read that misses issues exactly one block read (`bus_cmd` = 2'b01) for the request address, returns the word on `bus_rdata` from the grant cycle as `cpu_rdata` with `cpu_hit` = 0, and leaves the line `LN_VAL` with that tag and word.
- R3: A read that hits issues no bus transaction and returns the line's word with `cpu_hit` = 1, in the cycle after the lookup.
- R4: A write that misses issues a read-for-ownership (`bus_cmd` = 2'b10), then a word write (`bus_cmd` = 2'b11) that carries the store data, reports `cpu_hit` = 0, and leaves the line `LN_VAL` holding the store data.
- R5: A write that hits issues exactly one word write (`bus_cmd` = 2'b11) that carries the store data, reports `cpu_hit` = 1, and the line stays `LN_VAL` with the new word.
- R6: A snoop with `snp_cmd` equal to word write or read-for-ownership whose address matches a valid line makes that line `LN_INV` at the next edge. A snooped block read, or a snoop with a different tag on the same index, has no effect, and the controller never drives the bus in response.
- R7: A snoop that kills a line in the cycle of a processor lookup of the same line is applied first: a read then misses (block read), and a write misses and takes the read-for-ownership path.
- R8: While `bus_req` is 1 and `bus_gnt` is 0, `bus_cmd`, `bus_addr` and `bus_wdata` stay unchanged. A transaction completes in the cycle in which `bus_gnt` is 1, and `bus_addr` always equals the request address. Command encoding: 2'b00 none, 2'b01 block read, 2'b10 read-for-ownership, 2'b11 word write.
- R9: The line index is the low `IDX_W` address bits and the tag is the remaining bits. A fill with a new tag replaces the old line, and every request ends with a `cpu_done` pulse exactly one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Lookup hit flag, valid with `cpu_done` |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_cmd | output | 2 | Outgoing transaction kind |
| bus_addr | output | ADDR_W | Outgoing transaction address |
| bus_wdata | output | DATA_W | Outgoing write data |
| bus_rdata | input | DATA_W | Memory word returned in a block-read grant cycle |
| snp_valid | input | 1 | A transaction of another agent is on the bus |
| snp_cmd | input | 2 | Snooped transaction kind, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped transaction address |

## Verification
The bench builds the block with `ADDR_W` = 8, `IDX_W` = 2 and `DATA_W` = 16. That gives four lines and a 256-word memory model, and all addresses are drawn from four tags. With so few lines, random traffic keeps hitting the same lines, evicting them on tag conflicts, and meeting snoops on lines that are currently valid. Random grant delays leave the request waiting for several cycles, so snoops arrive while a word write is still pending. That covers the case where a line filled by a read-for-ownership is killed before its word write reaches memory.

// File: rtl/wtsc_pkg.sv
package wtsc_pkg;

    typedef enum logic [1:0] {
        CMD_NONE = 2'b00,
        CMD_RD   = 2'b01,
        CMD_RDX  = 2'b10,
        CMD_WR   = 2'b11
    } bus_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_BUS  = 2'b01,
        ST_RESP = 2'b10
    } ctl_state_e;

    typedef enum logic {
        LN_INV = 1'b0,
        LN_VAL = 1'b1
    } line_st_e;

endpackage

// File: rtl/wtsc_tag_array.sv
module wtsc_tag_array #(
    parameter int LINES = 64,
    parameter int IDX_W = 6,
    parameter int TAG_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag
);

    logic [TAG_W-1:0] tags [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                tags[i] <= '0;
            end
        end else if (wr_en) begin
            tags[wr_idx] <= wr_tag;
        end
    end

    assign rd_tag = tags[rd_idx];

endmodule

// File: rtl/wtsc_data_array.sv
module wtsc_data_array #(
    parameter int LINES  = 64,
    parameter int IDX_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] words [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                words[i] <= '0;
            end
        end else if (wr_en) begin
            words[wr_idx] <= wr_data;
        end
    end

    assign rd_data = words[rd_idx];

endmodule

// File: rtl/wtsc_line_state.sv
module wtsc_line_state
    import wtsc_pkg::*;
#(
    parameter int LINES = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kill_en,
    input  logic [IDX_W-1:0] kill_idx,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    output logic [LINES-1:0] valid
);

    line_st_e st [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        // the snoop is applied first; a fill in the same cycle then wins
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st[i] <= LN_INV;
            end else if (fill_en && (fill_idx == IDX_W'(i))) begin
                st[i] <= LN_VAL;
            end else if (kill_en && (kill_idx == IDX_W'(i))) begin
                st[i] <= LN_INV;
            end
        end
        assign valid[i] = (st[i] == LN_VAL);
    end

endmodule

// File: rtl/wtsc_ctrl_fsm.sv
module wtsc_ctrl_fsm
    import wtsc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6,
    parameter int TAG_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              lookup_hit,
    input  logic [DATA_W-1:0] lookup_data,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              cpu_done,
    output logic              cpu_hit,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output bus_cmd_e          bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              install_en,
    output logic              fill_en,
    output logic [DATA_W-1:0] fill_data,
    output logic [IDX_W-1:0]  line_idx,
    output logic [TAG_W-1:0]  line_tag
);

    ctl_state_e        state, state_nx;
    bus_cmd_e          cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              hit_q;
    logic              granted;

    assign granted = (state == ST_BUS) && bus_gnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cpu_req) begin
                    state_nx = (!cpu_we && lookup_hit) ? ST_RESP : ST_BUS;
                end
            end
            ST_BUS: begin
                if (bus_gnt && (cmd_q != CMD_RDX)) begin
                    state_nx = ST_RESP;
                end
            end
            ST_RESP: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // request capture and pending command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q   <= CMD_NONE;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            hit_q   <= 1'b0;
        end else if ((state == ST_IDLE) && cpu_req) begin
            addr_q  <= cpu_addr;
            wdata_q <= cpu_wdata;
            rdata_q <= lookup_data;
            hit_q   <= lookup_hit;
            if (cpu_we) begin
                cmd_q <= lookup_hit ? CMD_WR : CMD_RDX;
            end else begin
                cmd_q <= CMD_RD;
            end
        end else if (granted) begin
            if (cmd_q == CMD_RDX) begin
                cmd_q <= CMD_WR;
            end
            if (cmd_q == CMD_RD) begin
                rdata_q <= bus_rdata;
            end
        end
    end

    // outputs
    always_comb begin
        cpu_done   = (state == ST_RESP);
        cpu_hit    = (state == ST_RESP) && hit_q;
        cpu_rdata  = rdata_q;
        bus_req    = (state == ST_BUS);
        bus_cmd    = (state == ST_BUS) ? cmd_q : CMD_NONE;
        bus_addr   = addr_q;
        bus_wdata  = wdata_q;
        install_en = granted && (cmd_q != CMD_WR);
        fill_en    = granted;
        fill_data  = (cmd_q == CMD_RD) ? bus_rdata : wdata_q;
        line_idx   = addr_q[IDX_W-1:0];
        line_tag   = addr_q[ADDR_W-1:IDX_W];
    end

endmodule

// File: rtl/wt_snoop_ctrl.sv
module wt_snoop_ctrl
    import wtsc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic              cpu_hit,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr
);

    localparam int LINES      = 1 << IDX_W;
    localparam int TAG_W      = ADDR_W - IDX_W;
    localparam int TAG_COPIES = 2;   // copy 0 serves the processor, copy 1 the snooper

    logic [IDX_W-1:0]  cpu_idx, snoop_idx, line_idx;
    logic [TAG_W-1:0]  cpu_tag, snoop_tag, line_tag;
    logic [IDX_W-1:0]  probe_idx [TAG_COPIES];
    logic [TAG_W-1:0]  probe_tag [TAG_COPIES];
    logic [LINES-1:0]  line_valid;
    logic              snoop_kill, lookup_hit;
    logic              install_en, fill_en;
    logic [DATA_W-1:0] fill_data, lookup_data;
    bus_cmd_e          bus_cmd_w;

    assign cpu_idx   = cpu_addr[IDX_W-1:0];
    assign cpu_tag   = cpu_addr[ADDR_W-1:IDX_W];
    assign snoop_idx = snp_addr[IDX_W-1:0];
    assign snoop_tag = snp_addr[ADDR_W-1:IDX_W];

    assign probe_idx[0] = cpu_idx;
    assign probe_idx[1] = snoop_idx;

    for (genvar c = 0; c < TAG_COPIES; c++) begin : g_tag_copy
        wtsc_tag_array #(
            .LINES (LINES),
            .IDX_W (IDX_W),
            .TAG_W (TAG_W)
        ) u_tags (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (install_en),
            .wr_idx (line_idx),
            .wr_tag (line_tag),
            .rd_idx (probe_idx[c]),
            .rd_tag (probe_tag[c])
        );
    end

    assign snoop_kill = snp_valid
                     && ((snp_cmd == CMD_WR) || (snp_cmd == CMD_RDX))
                     && line_valid[snoop_idx]
                     && (probe_tag[1] == snoop_tag);

    assign lookup_hit = line_valid[cpu_idx]
                     && (probe_tag[0] == cpu_tag)
                     && !(snoop_kill && (snoop_idx == cpu_idx));

    wtsc_line_state #(
        .LINES (LINES),
        .IDX_W (IDX_W)
    ) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .kill_en  (snoop_kill),
        .kill_idx (snoop_idx),
        .fill_en  (install_en),
        .fill_idx (line_idx),
        .valid    (line_valid)
    );

    wtsc_data_array #(
        .LINES  (LINES),
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fill_en),
        .wr_idx  (line_idx),
        .wr_data (fill_data),
        .rd_idx  (cpu_idx),
        .rd_data (lookup_data)
    );

    wtsc_ctrl_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_req     (cpu_req),
        .cpu_we      (cpu_we),
        .cpu_addr    (cpu_addr),
        .cpu_wdata   (cpu_wdata),
        .lookup_hit  (lookup_hit),
        .lookup_data (lookup_data),
        .bus_gnt     (bus_gnt),
        .bus_rdata   (bus_rdata),
        .cpu_done    (cpu_done),
        .cpu_hit     (cpu_hit),
        .cpu_rdata   (cpu_rdata),
        .bus_req     (bus_req),
        .bus_cmd     (bus_cmd_w),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .install_en  (install_en),
        .fill_en     (fill_en),
        .fill_data   (fill_data),
        .line_idx    (line_idx),
        .line_tag    (line_tag)
    );

    assign bus_cmd = bus_cmd_w;

endmodule

// File: rtl/wtsc_checker.sv
module wtsc_checker
    import wtsc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6,
    parameter int LINES  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_done,
    input logic              cpu_hit,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic [1:0]        bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [LINES-1:0]  line_valid,
    input logic              snoop_kill,
    input logic [IDX_W-1:0]  snoop_idx,
    input logic              install_en,
    input logic [IDX_W-1:0]  install_idx
);

    assert_reset_inv_R1: assert property (@(posedge clk)
        !rst_n |=> (line_valid == '0));

    assert_rd_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && (bus_cmd == CMD_RD))
        |=> (cpu_done && (cpu_rdata == $past(bus_rdata))));

    assert_rdhit_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && cpu_hit && !cpu_we) |-> !$past(bus_req));

    assert_rdx_then_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && (bus_cmd == CMD_RDX))
        |=> (bus_req && (bus_cmd == CMD_WR)));

    assert_wrhit_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && cpu_hit && cpu_we)
        |-> (($past(bus_cmd) == CMD_WR) && $past(bus_gnt)));

    assert_snoop_inv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_kill && !(install_en && (install_idx == snoop_idx)))
        |=> !line_valid[$past(snoop_idx)]);

    assert_snoop_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && !bus_req && !cpu_done && snoop_kill
         && (snoop_idx == cpu_addr[IDX_W-1:0]))
        |=> (bus_req && (bus_cmd == CMD_RDX)));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt)
        |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr) && $stable(bus_wdata)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    assert_done_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> !bus_req);

endmodule

bind wt_snoop_ctrl wtsc_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .LINES  (LINES)
) u_wtsc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_req     (cpu_req),
    .cpu_we      (cpu_we),
    .cpu_addr    (cpu_addr),
    .cpu_done    (cpu_done),
    .cpu_hit     (cpu_hit),
    .cpu_rdata   (cpu_rdata),
    .bus_req     (bus_req),
    .bus_gnt     (bus_gnt),
    .bus_cmd     (bus_cmd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .line_valid  (line_valid),
    .snoop_kill  (snoop_kill),
    .snoop_idx   (snoop_idx),
    .install_en  (install_en),
    .install_idx (line_idx)
);

// File: tb/test_wt_snoop_ctrl.sv
module test_wt_snoop_ctrl;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int IW = 2;
    localparam int LN = 1 << IW;
    localparam int TW = AW - IW;
    localparam int MEMSZ = 1 << AW;

    localparam logic [1:0] C_RD  = 2'b01;
    localparam logic [1:0] C_RDX = 2'b10;
    localparam logic [1:0] C_WR  = 2'b11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_done, cpu_hit;
    logic [DW-1:0] cpu_rdata;
    logic          bus_req;
    logic          bus_gnt = 1'b0;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_cmd = 2'b00;
    logic [AW-1:0] snp_addr = '0;

    logic [DW-1:0] mem [MEMSZ];
    bit            mv  [LN];
    logic [TW-1:0] mt  [LN];
    logic [DW-1:0] md  [LN];

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    assign bus_rdata = mem[bus_addr];

    wt_snoop_ctrl #(
        .ADDR_W (AW),
        .DATA_W (DW),
        .IDX_W  (IW)
    ) i_wt_snoop_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_done  (cpu_done),
        .cpu_hit   (cpu_hit),
        .cpu_rdata (cpu_rdata),
        .bus_req   (bus_req),
        .bus_gnt   (bus_gnt),
        .bus_cmd   (bus_cmd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .snp_valid (snp_valid),
        .snp_cmd   (snp_cmd),
        .snp_addr  (snp_addr)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit model_hit(input logic [AW-1:0] a);
        return mv[a[IW-1:0]] && (mt[a[IW-1:0]] == a[AW-1:IW]);
    endfunction

    function automatic void model_snoop(input logic [1:0] c, input logic [AW-1:0] a);
        if (((c == C_WR) || (c == C_RDX)) && model_hit(a)) begin
            mv[a[IW-1:0]] = 1'b0;
        end
    endfunction

    function automatic void model_fill(input logic [AW-1:0] a, input logic [DW-1:0] d);
        mv[a[IW-1:0]] = 1'b1;
        mt[a[IW-1:0]] = a[AW-1:IW];
        md[a[IW-1:0]] = d;
    endfunction

    // one processor request; lookup-cycle snoop optional; rnd adds grant delay and snoops
    task automatic do_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input bit lk_snp, input logic [1:0] lk_cmd, input logic [AW-1:0] lk_a,
                         input bit rnd, input string ctx, output bit got_hit);
        bit            exp_hit;
        logic [DW-1:0] exp_rd;
        logic [1:0]    seen [2];
        int            ncmd = 0;
        int            guard = 0;
        bit            waited = 0;
        logic [1:0]    pc = 2'b00;
        logic [AW-1:0] pa = '0;
        logic [DW-1:0] pw = '0;
        string         kind;
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_addr  = a;
        cpu_wdata = wd;
        if (lk_snp) begin
            snp_valid = 1'b1;
            snp_cmd   = lk_cmd;
            snp_addr  = lk_a;
            model_snoop(lk_cmd, lk_a);
        end
        exp_hit = model_hit(a);
        exp_rd  = md[a[IW-1:0]];
        if (we) kind = exp_hit ? "R5" : "R4";
        else    kind = exp_hit ? "R3" : "R2";
        forever begin
            @(negedge clk);
            snp_valid = 1'b0;
            bus_gnt   = 1'b0;
            guard++;
            if (guard > 60) begin
                check({ctx, " ", kind}, "request never completed", 32'd0, 32'd1);
                break;
            end
            if (cpu_done) break;
            if (bus_req) begin
                if (waited) begin
                    check("R8", "cmd held while waiting", {30'd0, bus_cmd}, {30'd0, pc});
                    check("R8", "addr held while waiting", {24'd0, bus_addr}, {24'd0, pa});
                    check("R8", "wdata held while waiting", {16'd0, bus_wdata}, {16'd0, pw});
                end
                if (!rnd || ($urandom_range(2) != 0)) begin
                    bus_gnt = 1'b1;
                    waited  = 1'b0;
                    if (ncmd < 2) seen[ncmd] = bus_cmd;
                    ncmd++;
                    check("R8", "bus address", {24'd0, bus_addr}, {24'd0, a});
                    if (bus_cmd == C_RD) begin
                        exp_rd = mem[a];
                        model_fill(a, mem[a]);
                    end else if (bus_cmd == C_RDX) begin
                        model_fill(a, wd);
                    end else if (bus_cmd == C_WR) begin
                        check(kind, "word write data", {16'd0, bus_wdata}, {16'd0, wd});
                        mem[a] = bus_wdata;
                        if (model_hit(a)) md[a[IW-1:0]] = wd;
                    end
                end else begin
                    waited = 1'b1;
                    pc = bus_cmd;
                    pa = bus_addr;
                    pw = bus_wdata;
                    if ($urandom_range(1) == 1) begin
                        snp_valid = 1'b1;
                        snp_cmd   = 2'($urandom_range(3));
                        snp_addr  = {TW'($urandom_range(3)), IW'($urandom_range(LN - 1))};
                        model_snoop(snp_cmd, snp_addr);
                    end
                end
            end
        end
        got_hit = cpu_hit;
        check({ctx, " ", kind}, "hit flag", {31'd0, cpu_hit}, {31'd0, exp_hit});
        if (!we) check({ctx, " ", kind}, "read data", {16'd0, cpu_rdata}, {16'd0, exp_rd});
        if (!we && exp_hit) begin
            check("R3", "bus transactions", ncmd, 0);
        end else if (!we) begin
            check("R2", "bus transactions", ncmd, 1);
            if (ncmd >= 1) check("R2", "command", {30'd0, seen[0]}, {30'd0, C_RD});
        end else if (exp_hit) begin
            check("R5", "bus transactions", ncmd, 1);
            if (ncmd >= 1) check("R5", "command", {30'd0, seen[0]}, {30'd0, C_WR});
        end else begin
            check("R4", "bus transactions", ncmd, 2);
            if (ncmd >= 2) begin
                check("R4", "first command", {30'd0, seen[0]}, {30'd0, C_RDX});
                check("R4", "second command", {30'd0, seen[1]}, {30'd0, C_WR});
            end
        end
        cpu_req = 1'b0;
        @(negedge clk);
        check("R9", "done is a single pulse", {31'd0, cpu_done}, 32'd0);
    endtask

    task automatic idle_snoop(input logic [1:0] c, input logic [AW-1:0] a);
        snp_valid = 1'b1;
        snp_cmd   = c;
        snp_addr  = a;
        model_snoop(c, a);
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
        $finish;
    end

    initial begin
        bit h;
        int unused_seed;
        unused_seed = $urandom(32'h5eed);
        for (int i = 0; i < MEMSZ; i++) mem[i] = DW'(i * 37 + 11);
        for (int i = 0; i < LN; i++) begin
            mv[i] = 1'b0;
            mt[i] = '0;
            md[i] = '0;
        end
        repeat (3) @(negedge clk);
        check("R1", "bus_req in reset", {31'd0, bus_req}, 32'd0);
        check("R1", "cpu_done in reset", {31'd0, cpu_done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every line starts invalid
        for (int i = 0; i < LN; i++) begin
            do_op(1'b0, AW'(i), '0, 1'b0, 2'b00, '0, 1'b0, "R1", h);
            check("R1", "first read misses", {31'd0, h}, 32'd0);
        end
        // R3: read hit on a filled line
        do_op(1'b0, 8'h02, '0, 1'b0, 2'b00, '0, 1'b0, "R3", h);
        // R4: write miss replaces tag 0 in line 0; R9: old tag then misses
        do_op(1'b1, 8'h14, 16'hbeef, 1'b0, 2'b00, '0, 1'b0, "R4", h);
        do_op(1'b0, 8'h14, '0, 1'b0, 2'b00, '0, 1'b0, "R4", h);
        check("R4", "line valid after write miss", {31'd0, h}, 32'd1);
        do_op(1'b0, 8'h00, '0, 1'b0, 2'b00, '0, 1'b0, "R9", h);
        check("R9", "evicted tag misses", {31'd0, h}, 32'd0);
        // R5: write hit
        do_op(1'b1, 8'h00, 16'h1234, 1'b0, 2'b00, '0, 1'b0, "R5", h);
        do_op(1'b0, 8'h00, '0, 1'b0, 2'b00, '0, 1'b0, "R5", h);
        check("R5", "line stays valid", {31'd0, h}, 32'd1);
        // R6: remote word write kills the line
        idle_snoop(C_WR, 8'h01);
        do_op(1'b0, 8'h01, '0, 1'b0, 2'b00, '0, 1'b0, "R6", h);
        check("R6", "remote write invalidates", {31'd0, h}, 32'd0);
        // R6: remote read-for-ownership kills the line
        idle_snoop(C_RDX, 8'h01);
        do_op(1'b0, 8'h01, '0, 1'b0, 2'b00, '0, 1'b0, "R6", h);
        check("R6", "remote rdx invalidates", {31'd0, h}, 32'd0);
        // R6: remote block read, other tag on the same index: no effect
        idle_snoop(C_RD, 8'h01);
        do_op(1'b0, 8'h01, '0, 1'b0, 2'b00, '0, 1'b0, "R6", h);
        check("R6", "remote read leaves line", {31'd0, h}, 32'd1);
        idle_snoop(C_WR, 8'h21);
        do_op(1'b0, 8'h01, '0, 1'b0, 2'b00, '0, 1'b0, "R6", h);
        check("R6", "other tag leaves line", {31'd0, h}, 32'd1);
        // R7: snoop in the lookup cycle wins
        do_op(1'b1, 8'h01, 16'h5a5a, 1'b1, C_RDX, 8'h01, 1'b0, "R7", h);
        check("R7", "write after same-cycle kill misses", {31'd0, h}, 32'd0);
        do_op(1'b0, 8'h02, '0, 1'b1, C_WR, 8'h02, 1'b0, "R7", h);
        check("R7", "read after same-cycle kill misses", {31'd0, h}, 32'd0);

        // random traffic with grant delays and snoops
        for (int n = 0; n < 500; n++) begin
            logic [AW-1:0] a;
            logic [AW-1:0] sa;
            bit            ls;
            a  = {TW'($urandom_range(3)), IW'($urandom_range(LN - 1))};
            sa = ($urandom_range(1) == 1) ? a : {TW'($urandom_range(3)), IW'($urandom_range(LN - 1))};
            ls = ($urandom_range(3) == 0);
            do_op(1'($urandom_range(1)), a, DW'($urandom), ls, 2'($urandom_range(3)), sa,
                  1'b1, "random", h);
            if ($urandom_range(4) == 0) begin
                idle_snoop(2'($urandom_range(3)), {TW'($urandom_range(3)), IW'($urandom_range(LN - 1))});
            end
        end

        summary();
        $finish;
    end

endmodule